// File: doc/BRIEF.md
# Vectored Interrupt Pending and Enable Controller

This block collects 32 peripheral interrupt request lines and decides which one a processor core should take next. Each line owns an enable bit and a pending bit. Software reaches both through a small register window on a simple memory-mapped bus. The window has separate write-one-to-set and write-one-to-clear views, so a single store can change chosen bits without a read-modify-write sequence. A high level on a request line latches the pending bit whether or not the line is enabled.

On the core side, the controller presents a request valid flag and an exception number, equal to the line number plus 16. The core answers with an acknowledge pulse when it activates the handler, and with a return pulse when the handler finishes. A global mask bit, set and cleared by the core, holds back every request. Only one handler is active at a time. Among pending enabled lines, the lowest line number wins.

Once a line is active, it stays active until the return pulse. Disabling the line or clearing its pending bit while its handler runs does not end the activation.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset, all enable bits are 0, all pending bits are 0, no line is active (`active_num` = 0), the global mask is 0 and `req_valid` is 0.
- R2: The register views are selected by `bus_addr`: 0 is set-enable, 1 is clear-enable, 2 is set-pending and 3 is clear-pending. A write of 1 to bit n of view 0 enables line n, and a write of 1 to bit n of view 1 disables it. Zero bits leave the state unchanged. A read of view 0 or view 1 returns the enable vector, with bit n for line n.
- R3: Views 2 and 3 follow the same set and clear rule for the pending bits. A read of either view returns the pending vector.
- R4: A high level on `irq_lines[n]` sets pending bit n at the next clock edge even when line n is disabled. A disabled line never raises `req_valid`.
- R5: `req_valid` is 1 exactly when the mask is 0, no line is active and at least one line is both enabled and pending. `req_excnum` is then 16 plus the lowest such line number.
- R6: When `req_ack` is high while `req_valid` is 1, the chosen line's pending bit clears and the line becomes active at that edge. `active_num` then shows its exception number, and `req_valid` stays 0 while it is active.
- R7: Clearing the enable bit of the active line leaves it active.
- R8: A clear-pending write to the active line leaves it active.
- R9: An `exc_return` pulse ends the activation, so `active_num` returns to 0 at the next edge.
- R10: If a hardware assertion and a set-pending or clear-pending write reach the same line in the same cycle, the line ends up pending.
- R11: `mask_set` sets the global mask and `mask_clr` clears it. If both are high in the same cycle, set wins. The state is shown on `irq_masked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level request per peripheral line |
| bus_sel | input | 1 | Register window access strobe |
| bus_wr | input | 1 | Write when high, together with `bus_sel` |
| bus_addr | input | 2 | View select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected view |
| mask_set | input | 1 | Core sets the global mask |
| mask_clr | input | 1 | Core clears the global mask |
| irq_masked | output | 1 | Global mask state |
| req_valid | output | 1 | A request is offered to the core |
| req_excnum | output | 6 | Exception number of the offered request |
| req_ack | input | 1 | Core activates the offered request |
| exc_return | input | 1 | Core finishes the active handler |
| active_num | output | 6 | Exception number of the active line, 0 if none |

## Verification
The controller's internal state is reached through its own outputs. A wrong enable or pending bit shows up on the read views in the cycle right after the write or line assertion that caused it. It also shows up on `req_valid` and `req_excnum` in that same cycle, because selection is combinational from the registered state. A wrong active record shows up on `active_num` one edge after the acknowledge or return, and it keeps new requests blocked or unblocked from then on. The bench drives the same-cycle collisions of hardware assertions and bus writes, and checks the pending view right after them.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_IRQ_DEF  = 32;
  localparam int EXC_BASE_DEF = 16;

  typedef enum logic [1:0] {
    VIEW_EN_SET   = 2'd0,
    VIEW_EN_CLR   = 2'd1,
    VIEW_PEND_SET = 2'd2,
    VIEW_PEND_CLR = 2'd3
  } view_e;
endpackage

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_bits,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;
  logic         en_upd;

  always_comb begin
    en_upd = |(set_bits | clr_bits);
    en_d   = (en_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_req,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic p_d;
    logic p_en;
    always_comb begin
      p_en = hw_req[i] | sw_set[i] | sw_clr[i] | ack_clr[i];
      // a set source always wins over any clear source
      p_d  = hw_req[i] | sw_set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q[i] <= 1'b0;
      else if (p_en) pend_q[i] <= p_d;
    end
  end
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     en,
  input  logic             masked,
  input  logic             busy,
  output logic             take,
  output logic [IDX_W-1:0] take_idx
);
  logic [N-1:0] cand;

  always_comb begin
    cand     = pend & en;
    take     = (|cand) & ~masked & ~busy;
    take_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) take_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_IRQ  = NUM_IRQ_DEF,
  parameter int EXC_BASE = EXC_BASE_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  irq_lines,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic         mask_set,
  input  logic         mask_clr,
  output logic         irq_masked,
  output logic         req_valid,
  output logic [5:0]   req_excnum,
  input  logic         req_ack,
  input  logic         exc_return,
  output logic [5:0]   active_num
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam int EXC_W = 6;

  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ack_clr;
  logic [NUM_IRQ-1:0] en_q, pend_q;
  logic               wr_go;
  view_e              view;
  logic               take;
  logic [IDX_W-1:0]   take_idx;
  logic               mask_q, mask_d, mask_upd;
  logic               act_vld_q, act_vld_d, act_upd;
  logic [IDX_W-1:0]   act_idx_q, act_idx_d;
  logic               fire;

  always_comb begin
    view   = view_e'(bus_addr);
    wr_go  = bus_sel & bus_wr;
    en_set = (wr_go && view == VIEW_EN_SET)   ? bus_wdata[NUM_IRQ-1:0] : '0;
    en_clr = (wr_go && view == VIEW_EN_CLR)   ? bus_wdata[NUM_IRQ-1:0] : '0;
    pd_set = (wr_go && view == VIEW_PEND_SET) ? bus_wdata[NUM_IRQ-1:0] : '0;
    pd_clr = (wr_go && view == VIEW_PEND_CLR) ? bus_wdata[NUM_IRQ-1:0] : '0;
  end

  intc_enable_bank #(.N(NUM_IRQ)) u_en (
    .clk(clk), .rst_n(rst_n), .set_bits(en_set), .clr_bits(en_clr), .en_q(en_q)
  );

  intc_pend_bank #(.N(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_req(irq_lines[NUM_IRQ-1:0]),
    .sw_set(pd_set), .sw_clr(pd_clr), .ack_clr(ack_clr), .pend_q(pend_q)
  );

  intc_select #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_sel (
    .pend(pend_q), .en(en_q), .masked(mask_q), .busy(act_vld_q),
    .take(take), .take_idx(take_idx)
  );

  // next-state logic for mask and active record
  always_comb begin
    fire     = take & req_ack;
    ack_clr  = '0;
    if (fire) ack_clr[take_idx] = 1'b1;
    mask_upd = mask_set | mask_clr;
    mask_d   = mask_set;
    act_upd  = fire | exc_return;
    act_vld_d = fire;
    act_idx_d = fire ? take_idx : act_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (mask_upd) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld_q <= 1'b0;
      act_idx_q <= '0;
    end else if (act_upd) begin
      act_vld_q <= act_vld_d;
      act_idx_q <= act_idx_d;
    end
  end

  always_comb begin
    irq_masked = mask_q;
    req_valid  = take;
    req_excnum = take ? EXC_W'(take_idx) + EXC_W'(EXC_BASE) : '0;
    active_num = act_vld_q ? EXC_W'(act_idx_q) + EXC_W'(EXC_BASE) : '0;
    bus_rdata  = '0;
    case (view)
      VIEW_EN_SET, VIEW_EN_CLR:     bus_rdata[NUM_IRQ-1:0] = en_q;
      VIEW_PEND_SET, VIEW_PEND_CLR: bus_rdata[NUM_IRQ-1:0] = pend_q;
      default:                      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N  = 32,
  parameter int EW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_lines,
  input logic [N-1:0]  pend_q,
  input logic          irq_masked,
  input logic          req_valid,
  input logic [EW-1:0] req_excnum,
  input logic          req_ack,
  input logic          exc_return,
  input logic [EW-1:0] active_num
);
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |-> !req_valid); // R11
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_num != '0) |-> !req_valid); // R5
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> (active_num == $past(req_excnum))); // R6
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_num != '0) && !exc_return) |=> $stable(active_num)); // R7
  AST_RETURN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !(req_valid && req_ack)) |=> (active_num == '0)); // R9
  AST_HW_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) |=> ((pend_q & $past(irq_lines)) == $past(irq_lines))); // R10
endmodule

bind intc_vector_ctrl intc_chk #(.N(NUM_IRQ), .EW(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines[NUM_IRQ-1:0]), .pend_q(pend_q),
  .irq_masked(irq_masked), .req_valid(req_valid), .req_excnum(req_excnum),
  .req_ack(req_ack), .exc_return(exc_return), .active_num(active_num)
);

// File: tb/intc_vector_ctrl_tb.sv
`timescale 1ns/1ps
module intc_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mask_set = 1'b0, mask_clr = 1'b0;
  logic        irq_masked, req_valid;
  logic [5:0]  req_excnum, active_num;
  logic        req_ack = 1'b0, exc_return = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mask_set(mask_set), .mask_clr(mask_clr),
    .irq_masked(irq_masked), .req_valid(req_valid), .req_excnum(req_excnum),
    .req_ack(req_ack), .exc_return(exc_return), .active_num(active_num)
  );

  // {write view, write data, read view, expected read}
  localparam logic [67:0] VEC [7] = '{
    {2'd0, 32'hA5A5_0000, 2'd1, 32'hA5A5_0000},
    {2'd1, 32'h0000_0000, 2'd0, 32'hA5A5_0000},
    {2'd1, 32'h8400_0000, 2'd0, 32'h21A5_0000},
    {2'd2, 32'h0000_00F0, 2'd3, 32'h0000_00F0},
    {2'd3, 32'h0000_0030, 2'd2, 32'h0000_00C0},
    {2'd3, 32'hFFFF_FFFF, 2'd2, 32'h0000_0000},
    {2'd1, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_valid", {31'b0, req_valid}, 32'h0);
    check("R1 active_num", {26'b0, active_num}, 32'h0);
    check("R1 irq_masked", {31'b0, irq_masked}, 32'h0);
    bus_read(2'd0, rd); check("R1 enable view", rd, 32'h0);
    bus_read(2'd2, rd); check("R1 pending view", rd, 32'h0);

    // R2 / R3 vector table of set/clear views
    for (int k = 0; k < 7; k++) begin
      bus_write(VEC[k][67:66], VEC[k][65:34]);
      bus_read(VEC[k][33:32], rd);
      check(VEC[k][67:66] < 2 ? "R2 enable view" : "R3 pending view", rd, VEC[k][31:0]);
    end

    // R4 disabled line latches pending, no request
    @(negedge clk); irq_lines = 32'h20;
    @(negedge clk); irq_lines = 32'h0;
    bus_read(2'd2, rd); check("R4 pending latched", rd, 32'h20);
    check("R4 no request while disabled", {31'b0, req_valid}, 32'h0);
    bus_write(2'd0, 32'h0000_0220);
    check("R4 request after enable", {31'b0, req_valid}, 32'h1);
    check("R5 excnum line5", {26'b0, req_excnum}, 32'd21);

    // R5 lowest enabled pending wins
    bus_write(2'd2, 32'h0000_000C);
    check("R5 disabled line2 ignored", {26'b0, req_excnum}, 32'd21);
    bus_write(2'd0, 32'h0000_0008);
    check("R5 lowest line3 wins", {26'b0, req_excnum}, 32'd19);

    // R11 global mask
    pulse(mask_set);
    check("R11 masked flag", {31'b0, irq_masked}, 32'h1);
    check("R11 masked blocks", {31'b0, req_valid}, 32'h0);
    @(negedge clk); mask_set = 1'b1; mask_clr = 1'b1;
    @(negedge clk); mask_set = 1'b0; mask_clr = 1'b0;
    check("R11 set wins", {31'b0, irq_masked}, 32'h1);
    pulse(mask_clr);
    check("R11 unmask restores", {31'b0, req_valid}, 32'h1);

    // R6 acknowledge
    pulse(req_ack);
    check("R6 active_num", {26'b0, active_num}, 32'd19);
    check("R6 no request while active", {31'b0, req_valid}, 32'h0);
    bus_read(2'd3, rd); check("R6 pending cleared on ack", rd, 32'h24);

    // R7 disable active line
    bus_write(2'd1, 32'h0000_0008);
    check("R7 active survives disable", {26'b0, active_num}, 32'd19);
    // R8 clear-pending of active line
    bus_write(2'd2, 32'h0000_0008);
    bus_write(2'd3, 32'h0000_0008);
    check("R8 active survives clear-pending", {26'b0, active_num}, 32'd19);

    // R9 return
    pulse(exc_return);
    check("R9 active cleared", {26'b0, active_num}, 32'd0);
    check("R9 next request line5", {26'b0, req_excnum}, 32'd21);

    // R10 collisions
    @(negedge clk); irq_lines = 32'h100;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h100;
    @(negedge clk); irq_lines = 32'h80; bus_addr = 2'd3; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); irq_lines = 32'h0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    bus_read(2'd2, rd); check("R10 assertion beats clear", rd, 32'h80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule